// File: doc/BRIEF.md
# Event Time-Tag Capture Unit

This unit stamps external events with the time of day. A digital event line, which may change at any moment relative to the local clock, is brought into the clock domain through a flop chain. Each low-to-high transition then copies the current microsecond time-of-day value, supplied on an input port by a separate counter, into a holding register. A valid flag and a level interrupt request announce the new stamp. The stamp and flag stay put until the host pulses an acknowledge.

If a second rising edge arrives while a stamp is still waiting, that edge is dropped. The held value is kept, and a sticky lost-event flag is set. The host learns from it that at least one event went unrecorded. From the event line changing to the stamp appearing takes three clock cycles. Any clock of 4 MHz or more keeps the timestamp error below one microsecond. At 250 MHz the lag is 12 ns, far beyond what 200 events per second require.

Top module: `evt_stamp_top`

## Requirements
- R1: During and right after reset, `stamp_vld`, `overrun` and `irq` are 0 and `stamp_q` is all zeros.
- R2: A rising edge on `evt_in` sets `stamp_vld` after the third rising clock edge following the input change, through two synchroniser flops and one edge flop. `stamp_q` then holds the `tod_us` value present at that third clock edge.
- R3: A falling edge of `evt_in`, or a level held steady, never sets `stamp_vld` and never alters `stamp_q`.
- R4: While `stamp_vld` is 1 and `ack` is not asserted, `stamp_q` does not change, even though `tod_us` keeps advancing.
- R5: An `ack` pulse with no rising edge in the same cycle clears `stamp_vld` and `overrun` on the next clock edge.
- R6: A rising edge detected while `stamp_vld` is 1 and `ack` is 0 sets `overrun` and leaves `stamp_q` unchanged.
- R7: `overrun` stays 1 until an `ack` is seen, whatever `evt_in` does in the meantime.
- R8: A rising edge detected in the same cycle as `ack` loads a new stamp. `stamp_vld` stays 1 and `overrun` is cleared.
- R9: `irq` is 1 exactly when `stamp_vld` is 1 and `irq_en` was 1 on the previous clock edge. With `irq_en` at 0, `irq` stays 0 while a stamp is pending.
- R10: A series of events, each acknowledged before the next rising edge, is captured one by one with correct stamps and no `overrun`. Between edges the line must stay at each level for at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| evt_in | input | 1 | Asynchronous event line |
| tod_us | input | TS_W (48) | Current time of day in microseconds |
| irq_en | input | 1 | Interrupt enable |
| ack | input | 1 | One-cycle read acknowledge from the host |
| stamp_q | output | TS_W (48) | Captured time of day |
| stamp_vld | output | 1 | A stamp is held and unread |
| overrun | output | 1 | Sticky: an event was lost while a stamp was pending |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions watch on every cycle how the internal edge pulse relates to the outputs:
- a detected edge either loads the stamp or marks overrun, depending on the pending flag and `ack`;
- the held value stays stable while pending;
- `overrun` is sticky and never appears without a pending stamp;
- `irq` follows the registered enable and the valid flag.

Only the bench scenarios can show the fixed three-cycle latency from the pin to the stamp, counted against a running `tod_us`. They also show that falling edges and steady levels are ignored, and what happens when an edge and an `ack` land in the same cycle.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned DEF_TS_W  = 48;
  localparam int unsigned DEF_SYNC  = 2;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_LOSE  = 2'd2,
    ACT_CLEAR = 2'd3
  } cap_act_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= d_async;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign d_sync = chain[LAST];
endmodule

// File: rtl/evt_edge.sv
module evt_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import evt_pkg::*;
#(
  parameter int unsigned TS_W = DEF_TS_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise,
  input  logic [TS_W-1:0] tod_us,
  input  logic            irq_en,
  input  logic            ack,
  output logic [TS_W-1:0] stamp_q,
  output logic            stamp_vld,
  output logic            overrun,
  output logic            irq
);
  cap_act_e act;
  logic     vld_nxt;

  always_comb begin
    act = ACT_IDLE;
    if (rise && (!stamp_vld || ack)) act = ACT_LOAD;
    else if (rise)                   act = ACT_LOSE;
    else if (ack)                    act = ACT_CLEAR;
  end

  always_comb begin
    vld_nxt = stamp_vld;
    case (act)
      ACT_LOAD:  vld_nxt = 1'b1;
      ACT_CLEAR: vld_nxt = 1'b0;
      default:   vld_nxt = stamp_vld;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stamp_q   <= '0;
      stamp_vld <= 1'b0;
      overrun   <= 1'b0;
      irq       <= 1'b0;
    end else begin
      stamp_vld <= vld_nxt;
      irq       <= vld_nxt & irq_en;
      case (act)
        ACT_LOAD: begin
          stamp_q <= tod_us;
          overrun <= 1'b0;
        end
        ACT_LOSE:  overrun <= 1'b1;
        ACT_CLEAR: overrun <= 1'b0;
        default:   overrun <= overrun;
      endcase
    end
  end
endmodule

// File: rtl/evt_stamp_top.sv
module evt_stamp_top
  import evt_pkg::*;
#(
  parameter int unsigned TS_W      = DEF_TS_W,
  parameter int unsigned SYNC_DEPTH = DEF_SYNC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            evt_in,
  input  logic [TS_W-1:0] tod_us,
  input  logic            irq_en,
  input  logic            ack,
  output logic [TS_W-1:0] stamp_q,
  output logic            stamp_vld,
  output logic            overrun,
  output logic            irq
);
  logic evt_s;
  logic edge_p;

  evt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (evt_in),
    .d_sync  (evt_s)
  );

  evt_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  (evt_s),
    .rise (edge_p)
  );

  evt_capture #(.TS_W(TS_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .rise      (edge_p),
    .tod_us    (tod_us),
    .irq_en    (irq_en),
    .ack       (ack),
    .stamp_q   (stamp_q),
    .stamp_vld (stamp_vld),
    .overrun   (overrun),
    .irq       (irq)
  );
endmodule

// File: rtl/evt_stamp_chk.sv
module evt_stamp_chk #(
  parameter int unsigned TS_W = 48
) (
  input logic            clk,
  input logic            rst,
  input logic            edge_p,
  input logic [TS_W-1:0] tod_us,
  input logic            irq_en,
  input logic            ack,
  input logic [TS_W-1:0] stamp_q,
  input logic            stamp_vld,
  input logic            overrun,
  input logic            irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!stamp_vld && !overrun && !irq && stamp_q == '0));

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    edge_p && (!stamp_vld || ack) |=> stamp_vld && stamp_q == $past(tod_us));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    stamp_vld && !ack && !edge_p |=> $stable(stamp_q));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ack && !edge_p |=> !stamp_vld && !overrun);

  // R6
  lose_event_chk: assert property (@(posedge clk) disable iff (rst)
    edge_p && stamp_vld && !ack |=> overrun && $stable(stamp_q));

  // R7
  sticky_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    overrun && !ack |=> overrun);

  // R7
  ovr_needs_vld_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |-> stamp_vld);

  // R8
  same_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    edge_p && ack |=> stamp_vld && !overrun);

  // R9
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (irq == ($past(irq_en) && stamp_vld)));
endmodule

bind evt_stamp_top evt_stamp_chk #(.TS_W(TS_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .edge_p    (edge_p),
  .tod_us    (tod_us),
  .irq_en    (irq_en),
  .ack       (ack),
  .stamp_q   (stamp_q),
  .stamp_vld (stamp_vld),
  .overrun   (overrun),
  .irq       (irq)
);

// File: tb/sim_evt_stamp_top.sv
module sim_evt_stamp_top;
  localparam int TS_W = 48;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            evt_in = 1'b0;
  logic [TS_W-1:0] tod_us = '0;
  logic            irq_en = 1'b1;
  logic            ack = 1'b0;
  logic [TS_W-1:0] stamp_q;
  logic            stamp_vld;
  logic            overrun;
  logic            irq;

  int total = 0;
  int bad = 0;
  logic [TS_W-1:0] t0;

  evt_stamp_top #(.TS_W(TS_W)) u0 (
    .clk(clk), .rst(rst), .evt_in(evt_in), .tod_us(tod_us),
    .irq_en(irq_en), .ack(ack), .stamp_q(stamp_q),
    .stamp_vld(stamp_vld), .overrun(overrun), .irq(irq)
  );

  always #2 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tod_us = tod_us + 1;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [TS_W-1:0] act,
                       input logic [TS_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  // raise evt_in, return tod seen at the change, wait through the 3 edges
  task automatic raise_evt(output logic [TS_W-1:0] t);
    tick();
    evt_in = 1'b1;
    t = tod_us;
    tick(); tick(); tick();
  endtask

  task automatic drop_evt();
    tick();
    evt_in = 1'b0;
    tick(); tick(); tick();
  endtask

  task automatic t_reset();
    check("R1 vld", {47'd0, stamp_vld}, 48'd0);
    check("R1 ovr", {47'd0, overrun}, 48'd0);
    check("R1 irq", {47'd0, irq}, 48'd0);
    check("R1 stamp", stamp_q, 48'd0);
  endtask

  task automatic t_basic();
    raise_evt(t0);
    check("R2 vld", {47'd0, stamp_vld}, 48'd1);
    check("R2 stamp", stamp_q, t0 + 2);
    check("R9 irq on", {47'd0, irq}, 48'd1);
  endtask

  task automatic t_hold();
    repeat (5) tick();
    check("R4 stamp held", stamp_q, t0 + 2);
    check("R4 vld held", {47'd0, stamp_vld}, 48'd1);
  endtask

  task automatic t_ack();
    pulse_ack();
    check("R5 vld clr", {47'd0, stamp_vld}, 48'd0);
    check("R9 irq off", {47'd0, irq}, 48'd0);
  endtask

  task automatic t_falling();
    drop_evt();
    repeat (3) tick();
    check("R3 fall no vld", {47'd0, stamp_vld}, 48'd0);
    check("R3 fall stamp", stamp_q, t0 + 2);
  endtask

  task automatic t_overrun();
    logic [TS_W-1:0] t1;
    logic [TS_W-1:0] t2;
    raise_evt(t1);
    drop_evt();
    check("R6 no ovr yet", {47'd0, overrun}, 48'd0);
    raise_evt(t2);
    check("R6 ovr set", {47'd0, overrun}, 48'd1);
    check("R6 stamp kept", stamp_q, t1 + 2);
    drop_evt();
    repeat (4) tick();
    check("R7 ovr sticky", {47'd0, overrun}, 48'd1);
    check("R3 high level no new", stamp_q, t1 + 2);
    t0 = t1;
  endtask

  task automatic t_same_cycle();
    logic [TS_W-1:0] t3;
    tick();
    evt_in = 1'b1;
    t3 = tod_us;
    tick(); tick();
    ack = 1'b1;
    tick();
    ack = 1'b0;
    check("R8 vld", {47'd0, stamp_vld}, 48'd1);
    check("R8 stamp", stamp_q, t3 + 2);
    check("R8 ovr clr", {47'd0, overrun}, 48'd0);
    drop_evt();
    pulse_ack();
    check("R5 ovr clr", {47'd0, overrun}, 48'd0);
  endtask

  task automatic t_irq_mask();
    logic [TS_W-1:0] t4;
    irq_en = 1'b0;
    raise_evt(t4);
    check("R9 masked vld", {47'd0, stamp_vld}, 48'd1);
    check("R9 masked irq", {47'd0, irq}, 48'd0);
    irq_en = 1'b1;
    tick();
    check("R9 unmask irq", {47'd0, irq}, 48'd1);
    drop_evt();
    pulse_ack();
  endtask

  task automatic t_series();
    for (int k = 0; k < 5; k++) begin
      logic [TS_W-1:0] tk;
      raise_evt(tk);
      check("R10 stamp", stamp_q, tk + 2);
      check("R10 no ovr", {47'd0, overrun}, 48'd0);
      pulse_ack();
      drop_evt();
    end
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_reset();
    t_basic();
    t_hold();
    t_ack();
    t_falling();
    t_overrun();
    t_same_cycle();
    t_irq_mask();
    t_series();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule